// File: doc/BRIEF.md
# One-Wire ROM Search Step Engine

This block carries out a single bit position of the one-wire ROM search. A pulse on `start` while the engine is idle begins the step. The engine captures the preferred branch bit and asks an external time-slot generator for two read slots. The first sample is the device ID bit and the second is its complement. The engine then picks the branch to follow. Unless the two samples show a conflict, it asks the generator for one write slot that carries the chosen branch bit.

Each slot is a held command with a one-cycle completion strobe. A higher-level search controller calls the engine once for each bit position and handles discrepancies and CRC itself. The result is a 3-bit status word. It is announced by a one-cycle `done` pulse and stays unchanged until the next accepted start.

Top module: `owt_search_step`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `busy`, `done` and `slot_cmd_valid` are 0, and `status` is 3'b000.
- R2: An accepted start sets `busy` and raises `slot_cmd_valid` with `slot_cmd_kind` = 0 (0 = read, 1 = write) in the next cycle. The first two slots of every step are reads. The first read's sample is the ID bit and the second read's sample is the complement bit.
- R3: If both samples are 1, the step ends after the two reads with `status` = 3'b011, and no write slot is requested.
- R4: If both samples are 0, the branch is the preferred bit captured at start. `status` is 3'b100 for 1 and 3'b000 for 0, and a write slot carrying that bit follows.
- R5: If the ID sample is 1 and the complement sample is 0, `status` is 3'b101 and a write slot carrying 1 follows.
- R6: If the ID sample is 0 and the complement sample is 1, `status` is 3'b010 and a write slot carrying 0 follows.
- R7: `done` is high for exactly one cycle: the cycle after the clock edge that samples `slot_done` for the last slot of the step. `status` (bit 2 = branch, bit 1 = complement, bit 0 = ID) then holds until the next accepted start.
- R8: A `start` pulse while `busy` is high has no effect on the slots requested or on the status word.
- R9: A slot command keeps `slot_cmd_valid`, `slot_cmd_kind` and `slot_cmd_bit` steady until the edge that samples `slot_done` high.
- R10: `pref_dir` is sampled only on the edge that accepts `start`. Later changes during the step do not alter the branch taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a search step (ignored when busy) |
| pref_dir | input | 1 | Branch bit used when both samples are 0 |
| slot_cmd_valid | output | 1 | A slot command is pending |
| slot_cmd_kind | output | 1 | 0 = read slot, 1 = write slot |
| slot_cmd_bit | output | 1 | Bit to send in a write slot (0 for reads) |
| slot_done | input | 1 | One-cycle completion strobe from the slot generator |
| slot_rbit | input | 1 | Sampled line level, valid with `slot_done` on a read |
| busy | output | 1 | Step in progress |
| done | output | 1 | One-cycle end-of-step pulse |
| status | output | 3 | {branch, complement bit, ID bit} |

## Verification
The hardest situation to create is a second `start` that arrives in the middle of a step. It has to land while a slot command is still waiting for its completion. The bench model of the slot generator delays each completion by a set number of cycles. With a long delay, the driver fires a second start with the opposite preferred bit inside that window. The scoreboard then checks that the slot count, the slot kinds, the write bit and the status all still match the first request. The bench also flips `pref_dir` right after every accepted start, so a design that samples it late takes the wrong branch in the both-zero case.

// File: rtl/owt_pkg.sv
package owt_pkg;

    localparam int STATUS_W = 3;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_RD_ID  = 3'd1,
        ST_RD_CMP = 3'd2,
        ST_WR     = 3'd3,
        ST_FIN    = 3'd4
    } step_st_t;

    typedef enum logic {
        SLOT_READ  = 1'b0,
        SLOT_WRITE = 1'b1
    } slot_kind_t;

    // packed order gives bit 2 = branch, bit 1 = complement, bit 0 = id
    typedef struct packed {
        logic dir;
        logic cmp;
        logic id;
    } step_status_t;

    typedef struct packed {
        logic       valid;
        slot_kind_t kind;
        logic       wbit;
    } slot_cmd_t;

    typedef struct packed {
        logic dir;
        logic conflict;
    } branch_t;

    function automatic branch_t pick_branch(logic id, logic cmp, logic pref);
        branch_t b;
        b.conflict = id & cmp;
        if (id ^ cmp)
            b.dir = id;
        else if (!id)
            b.dir = pref;
        else
            b.dir = 1'b0;
        return b;
    endfunction

endpackage

// File: rtl/owt_decide.sv
module owt_decide
    import owt_pkg::*;
(
    input  logic id_bit,
    input  logic cmp_bit,
    input  logic pref,
    output logic dir,
    output logic conflict
);
    branch_t br;

    always_comb begin
        br       = pick_branch(id_bit, cmp_bit, pref);
        dir      = br.dir;
        conflict = br.conflict;
    end
endmodule

// File: rtl/owt_ctrl.sv
module owt_ctrl
    import owt_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         pref_dir,
    input  logic         slot_done,
    input  logic         slot_rbit,
    input  logic         dec_dir,
    input  logic         dec_conflict,
    output logic         id_q,
    output logic         pref_q,
    output step_st_t     state,
    output step_status_t status_q
);
    step_st_t     state_n;
    step_status_t status_n;
    logic         id_n;
    logic         pref_n;

    always_comb begin
        state_n  = state;
        status_n = status_q;
        id_n     = id_q;
        pref_n   = pref_q;
        case (state)
            ST_IDLE: begin
                if (start) begin
                    pref_n  = pref_dir;
                    state_n = ST_RD_ID;
                end
            end
            ST_RD_ID: begin
                if (slot_done) begin
                    id_n    = slot_rbit;
                    state_n = ST_RD_CMP;
                end
            end
            ST_RD_CMP: begin
                if (slot_done) begin
                    status_n.id  = id_q;
                    status_n.cmp = slot_rbit;
                    status_n.dir = dec_dir;
                    state_n      = dec_conflict ? ST_FIN : ST_WR;
                end
            end
            ST_WR: begin
                if (slot_done)
                    state_n = ST_FIN;
            end
            ST_FIN:  state_n = ST_IDLE;
            default: state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            status_q <= '0;
            id_q     <= 1'b0;
            pref_q   <= 1'b0;
        end else begin
            state    <= state_n;
            status_q <= status_n;
            id_q     <= id_n;
            pref_q   <= pref_n;
        end
    end
endmodule

// File: rtl/owt_slot_drv.sv
module owt_slot_drv
    import owt_pkg::*;
(
    input  step_st_t  state,
    input  logic      dir,
    output slot_cmd_t cmd
);
    always_comb begin
        cmd = '0;
        case (state)
            ST_RD_ID, ST_RD_CMP: begin
                cmd.valid = 1'b1;
                cmd.kind  = SLOT_READ;
                cmd.wbit  = 1'b0;
            end
            ST_WR: begin
                cmd.valid = 1'b1;
                cmd.kind  = SLOT_WRITE;
                cmd.wbit  = dir;
            end
            default: cmd = '0;
        endcase
    end
endmodule

// File: rtl/owt_search_step.sv
module owt_search_step
    import owt_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                pref_dir,
    output logic                slot_cmd_valid,
    output logic                slot_cmd_kind,
    output logic                slot_cmd_bit,
    input  logic                slot_done,
    input  logic                slot_rbit,
    output logic                busy,
    output logic                done,
    output logic [STATUS_W-1:0] status
);
    step_st_t     state;
    step_status_t status_q;
    slot_cmd_t    cmd;
    logic         id_q;
    logic         pref_q;
    logic         dec_dir;
    logic         dec_conflict;

    // complement sample is decided live, in the cycle it arrives
    owt_decide u_decide (
        .id_bit   (id_q),
        .cmp_bit  (slot_rbit),
        .pref     (pref_q),
        .dir      (dec_dir),
        .conflict (dec_conflict)
    );

    owt_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .pref_dir     (pref_dir),
        .slot_done    (slot_done),
        .slot_rbit    (slot_rbit),
        .dec_dir      (dec_dir),
        .dec_conflict (dec_conflict),
        .id_q         (id_q),
        .pref_q       (pref_q),
        .state        (state),
        .status_q     (status_q)
    );

    owt_slot_drv u_slot (
        .state (state),
        .dir   (status_q.dir),
        .cmd   (cmd)
    );

    assign slot_cmd_valid = cmd.valid;
    assign slot_cmd_kind  = cmd.kind;
    assign slot_cmd_bit   = cmd.wbit;
    assign busy           = (state != ST_IDLE);
    assign done           = (state == ST_FIN);
    assign status         = status_q;
endmodule

// File: rtl/owt_search_step_chk.sv
module owt_search_step_chk (
    input logic       clk,
    input logic       rst,
    input logic       start,
    input logic       busy,
    input logic       done,
    input logic [2:0] status,
    input logic       slot_cmd_valid,
    input logic       slot_cmd_kind,
    input logic       slot_cmd_bit,
    input logic       slot_done
);
    AST_IDLE_NO_CMD: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !slot_cmd_valid); // R2

    AST_START_READS_FIRST: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (busy && slot_cmd_valid && !slot_cmd_kind)); // R2

    AST_NO_WRITE_ON_CONFLICT: assert property (@(posedge clk) disable iff (rst)
        (slot_cmd_valid && slot_cmd_kind) |-> !(status[0] && status[1])); // R3

    AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (rst)
        done |-> (status != 3'b001 && status[2:1] != 2'b11)); // R5

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R7

    AST_DONE_AFTER_SLOT: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(slot_done)); // R7

    AST_STATUS_HELD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !busy |=> $stable(status)); // R7

    AST_CMD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (slot_cmd_valid && !slot_done) |=>
            (slot_cmd_valid && $stable(slot_cmd_kind) && $stable(slot_cmd_bit))); // R9
endmodule

bind owt_search_step owt_search_step_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .start          (start),
    .busy           (busy),
    .done           (done),
    .status         (status),
    .slot_cmd_valid (slot_cmd_valid),
    .slot_cmd_kind  (slot_cmd_kind),
    .slot_cmd_bit   (slot_cmd_bit),
    .slot_done      (slot_done)
);

// File: tb/sim_owt_search_step.sv
module sim_owt_search_step;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       pref_dir = 1'b0;
    logic       slot_cmd_valid, slot_cmd_kind, slot_cmd_bit;
    logic       slot_done, slot_rbit;
    logic       busy, done;
    logic [2:0] status;

    int checks = 0;
    int errors = 0;

    // slot generator model state
    int       g_lat = 0;
    int       g_n = 0;
    int       g_rd = 0;
    logic     g_id = 1'b0, g_cmp = 1'b0;
    logic [2:0] g_kinds = '0;
    logic     g_wbit = 1'b0;

    typedef struct {
        logic [2:0] st;
        int         nslot;
        logic [2:0] kinds;
        logic       wbit;
        string      req;
    } exp_t;
    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    owt_search_step u0 (
        .clk            (clk),
        .rst            (rst),
        .start          (start),
        .pref_dir       (pref_dir),
        .slot_cmd_valid (slot_cmd_valid),
        .slot_cmd_kind  (slot_cmd_kind),
        .slot_cmd_bit   (slot_cmd_bit),
        .slot_done      (slot_done),
        .slot_rbit      (slot_rbit),
        .busy           (busy),
        .done           (done),
        .status         (status)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // slot generator: completes each command after g_lat cycles
    initial begin
        logic k, b;
        slot_done = 1'b0;
        slot_rbit = 1'b0;
        @(negedge clk);
        forever begin
            if (slot_cmd_valid !== 1'b1) begin
                @(negedge clk);
            end else begin
                k = slot_cmd_kind;
                b = slot_cmd_bit;
                repeat (g_lat) begin
                    @(negedge clk);
                    chk(slot_cmd_valid === 1'b1 && slot_cmd_kind === k && slot_cmd_bit === b,
                        "R9 command held", {slot_cmd_valid, slot_cmd_kind, slot_cmd_bit}, {1'b1, k, b});
                end
                if (g_n < 3) g_kinds[g_n] = k;
                g_n++;
                if (k) begin
                    g_wbit = b;
                    slot_rbit = 1'b0;
                end else begin
                    slot_rbit = (g_rd == 0) ? g_id : g_cmp;
                    g_rd++;
                end
                slot_done = 1'b1;
                @(negedge clk);
                slot_done = 1'b0;
            end
        end
    end

    // monitor: compares each finished step with the scoreboard
    initial begin
        exp_t e;
        logic prev_done = 1'b0;
        forever begin
            @(negedge clk);
            if (!rst && done === 1'b1) begin
                chk(!prev_done, "R7 done single pulse", 1, 0);
                if (sb.size() == 0) begin
                    chk(1'b0, "R7 unexpected done", 1, 0);
                end else begin
                    e = sb.pop_front();
                    chk(status === e.st, {e.req, " status"}, status, e.st);
                    chk(g_n == e.nslot, {e.req, " slot count"}, g_n, e.nslot);
                    chk(g_kinds === e.kinds, {e.req, " R2 slot kinds"}, g_kinds, e.kinds);
                    if (e.nslot == 3)
                        chk(g_wbit === e.wbit, {e.req, " write bit"}, g_wbit, e.wbit);
                end
            end
            prev_done = (done === 1'b1);
        end
    end

    // driver: one search step, optionally with a start poked while busy
    task automatic run_step(input logic pref, input logic id, input logic cmp,
                            input int lat, input logic poke);
        exp_t e;
        logic dir;
        while (busy) @(negedge clk);
        g_id = id; g_cmp = cmp; g_lat = lat;
        g_n = 0; g_rd = 0; g_kinds = '0; g_wbit = 1'b0;
        if (id && cmp) begin
            e.st = 3'b011; e.nslot = 2; e.kinds = 3'b000; e.wbit = 1'b0;
            e.req = "R3";
        end else begin
            dir = (id ^ cmp) ? id : pref;
            e.st = {dir, cmp, id}; e.nslot = 3; e.kinds = 3'b100; e.wbit = dir;
            e.req = (id ^ cmp) ? (id ? "R5" : "R6") : "R4 R10";
        end
        if (poke) e.req = {e.req, " R8"};
        sb.push_back(e);
        start = 1'b1; pref_dir = pref;
        @(negedge clk);
        start = 1'b0; pref_dir = ~pref;
        chk(busy === 1'b1 && slot_cmd_valid === 1'b1 && slot_cmd_kind === 1'b0,
            "R2 first command is read", {busy, slot_cmd_valid, slot_cmd_kind}, 3'b110);
        if (poke) begin
            repeat (2) @(negedge clk);
            start = 1'b1; pref_dir = ~pref;
            @(negedge clk);
            start = 1'b0;
        end
        while (done !== 1'b1) @(negedge clk);
        @(negedge clk);
        chk(done === 1'b0, "R7 done low after pulse", done, 0);
        repeat (3) @(negedge clk);
        chk(status === e.st && busy === 1'b0, "R7 status held", status, e.st);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(busy === 1'b0 && done === 1'b0 && slot_cmd_valid === 1'b0 && status === 3'b000,
            "R1 reset state", {busy, done, slot_cmd_valid, status}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(busy === 1'b0 && done === 1'b0 && slot_cmd_valid === 1'b0 && status === 3'b000,
            "R1 after reset", {busy, done, slot_cmd_valid, status}, 0);

        run_step(1'b1, 1'b1, 1'b1, 0, 1'b0); // R3
        run_step(1'b0, 1'b0, 1'b0, 1, 1'b0); // R4
        run_step(1'b1, 1'b0, 1'b0, 2, 1'b0); // R4 R10
        run_step(1'b0, 1'b1, 1'b0, 0, 1'b0); // R5
        run_step(1'b1, 1'b0, 1'b1, 3, 1'b0); // R6
        run_step(1'b0, 1'b1, 1'b1, 4, 1'b1); // R3 R8
        run_step(1'b1, 1'b0, 1'b0, 5, 1'b1); // R4 R8
        run_step(1'b0, 1'b0, 1'b1, 5, 1'b1); // R6 R8
        for (int i = 0; i < 16; i++)
            run_step(i[0], i[1], i[2], i % 4, 1'b0);

        repeat (4) @(negedge clk);
        chk(sb.size() == 0, "R7 all steps completed", sb.size(), 0);
        finish_run();
    end
endmodule